// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block turns pairs of two's complement PCM samples (one left, one right) into a single serial data line. The bit clock and word select come from outside the block, from another device or from a separate generator. Both are sampled in the system clock domain. The serial output changes one system clock after each detected falling edge of the bit clock, so a receiver can take it on the rising edge.

Sample pairs arrive through a one-deep valid/ready buffer. At each frame start the buffered pair moves into the active pair. If the buffer is empty at that moment, the old pair is sent again and an underrun pulse is raised.

Runtime inputs choose the alignment and the lengths:
- Alignment: standard one-bit-delayed, left-justified or right-justified.
- Word length: 16, 24 or 32 bits.
- Slot width: 16, 24 or 32 bits.

All three settings take effect only at a frame start.

Top module: `aud_serial_tx`

## Requirements
- R1: Reset state: while and after `rst_ni` is low, `sd_o` is 0, `ready_o` is 1 and `underrun_o` is 0.
- R2: Samples occupy bits [W-1:0] of `left_i`/`right_i`, where W is the word length. Bit W-1 is the sign. Input bits above W have no effect on `sd_o`, and the word is sent MSB first.
- R3: Bit period 0 of a slot is the period that starts at the bit clock fall where word select changes. In standard format (`fmt_i` = 0 or 3), the MSB is sent in bit period 1, the following bits come in order, and the periods after the LSB are 0.
- R4: Left-justified (`fmt_i` = 1): the MSB is sent in bit period 0 and the periods after the LSB are 0.
- R5: Right-justified (`fmt_i` = 2): the LSB is sent in the last bit period of the slot (period S-1), and the S-W leading periods carry copies of the sign bit.
- R6: Standard format: bit period 0 of each slot carries the last bit of the previous slot. That is the previous word's LSB when W equals S, and 0 otherwise.
- R7: Word select low (0) selects the left sample and high (1) selects the right sample.
- R8: `sd_o` changes only in the system clock cycle that follows a detected bit clock fall, and it is stable for the rest of the bit period.
- R9: `ready_o` is 1 exactly when the one-pair buffer is empty. A pair is taken when `valid_i` and `ready_o` are both 1, and the buffer empties at the next frame start (word select falling to 0).
- R10: If the buffer is empty at a frame start, the previous pair is sent again and `underrun_o` is 1 for exactly one system clock cycle.
- R11: Format, word length and slot width are captured at the frame start. Changes to `fmt_i`, `wlen_i` or `slot_i` during a frame have no effect until the next frame start.
- R12: Length codes on `wlen_i` and `slot_i` are 0 = 16, 1 = 24, 2 or 3 = 32. A word length larger than the slot width is reduced to the slot width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, sampled in the system clock domain |
| ws_i | input | 1 | Word select, 0 = left, 1 = right |
| fmt_i | input | 2 | Alignment: 0/3 standard, 1 left-justified, 2 right-justified |
| wlen_i | input | 2 | Word length code |
| slot_i | input | 2 | Slot width code |
| valid_i | input | 1 | Sample pair valid |
| left_i | input | 32 | Left sample, right-aligned |
| right_i | input | 32 | Right sample, right-aligned |
| ready_o | output | 1 | Buffer can take a pair |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse when a pair is repeated |

## Verification
Assertions check the following on every cycle:
- The serial line changes only right after a bit clock fall.
- The underrun pulse lasts a single cycle.
- The buffer handshake behaves as specified.
- The first bit of a left-justified slot is the MSB.
- The last bit of a right-justified slot is the LSB.
- The bit carried into a standard slot is the previous slot's last bit.

Other behaviours can only be shown by the bench's frame scenarios, because each needs a whole frame compared bit for bit against a model:
- sign extension in right-justified padding;
- zero padding in left-justified and standard slots;
- masking of input bits above the word length;
- length clamping;
- pair repetition after an underrun;
- ignoring configuration changes made mid-frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_STD  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_STD3 = 2'd3
  } fmt_e;

  // R12: 0 -> 16, 1 -> 24, 2/3 -> 32
  function automatic logic [5:0] len_decode(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_slot_timer.sv
module aud_tx_slot_timer #(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             ws_i,
  output logic             fall_o,
  output logic             new_slot_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_nx_o
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             bclk_q;
  logic             ws_q;
  logic [POS_W-1:0] pos_q;

  assign fall_o        = bclk_q & ~bclk_i;
  assign new_slot_o    = fall_o & (ws_i != ws_q);
  assign frame_start_o = new_slot_o & ~ws_i;

  always_comb begin
    if (new_slot_o)          pos_nx_o = '0;
    else if (!fall_o)        pos_nx_o = pos_q;
    else if (pos_q == POS_MAX) pos_nx_o = pos_q;
    else                     pos_nx_o = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      ws_q   <= 1'b1;
      pos_q  <= '0;
    end else begin
      bclk_q <= bclk_i;
      pos_q  <= pos_nx_o;
      if (fall_o) ws_q <= ws_i;
    end
  end

endmodule

// File: rtl/aud_tx_pair_buf.sv
module aud_tx_pair_buf #(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] left_nx_o,
  output logic [SAMPLE_W-1:0] right_nx_o,
  output logic                underrun_o
);

  logic                pend_q;
  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
  logic [SAMPLE_W-1:0] act_l_q, act_r_q;
  logic                take;

  assign ready_o    = ~pend_q;
  assign take       = load_i & pend_q;
  // next active pair, visible in the load cycle
  assign left_nx_o  = take ? pend_l_q : act_l_q;
  assign right_nx_o = take ? pend_r_q : act_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_l_q   <= '0;
      pend_r_q   <= '0;
      act_l_q    <= '0;
      act_r_q    <= '0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= load_i & ~pend_q;
      if (take) begin
        act_l_q <= pend_l_q;
        act_r_q <= pend_r_q;
      end
      if (valid_i && !pend_q) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
        pend_q   <= 1'b1;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_accept_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  p_load_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !ready_o) |=> ready_o);

endmodule

// File: rtl/aud_tx_bit_sel.sv
module aud_tx_bit_sel
  import aud_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned POS_W    = 6
) (
  input  fmt_e                fmt_i,
  input  logic [POS_W-1:0]    wl_i,
  input  logic [POS_W-1:0]    sl_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                carry_i,
  output logic                bit_o
);

  localparam int unsigned IDX_W = POS_W - 1;

  logic [POS_W-1:0] pad, i_lj, i_sign, i_rj, i_std;

  always_comb begin
    pad    = sl_i - wl_i;
    i_lj   = wl_i - POS_W'(1) - pos_i;
    i_sign = wl_i - POS_W'(1);
    i_rj   = sl_i - POS_W'(1) - pos_i;
    i_std  = wl_i - pos_i;
    bit_o  = 1'b0;
    case (fmt_i)
      FMT_LJ: begin
        if (pos_i < wl_i) bit_o = word_i[i_lj[IDX_W-1:0]];
      end
      FMT_RJ: begin
        if (pos_i < pad)       bit_o = word_i[i_sign[IDX_W-1:0]];
        else if (pos_i < sl_i) bit_o = word_i[i_rj[IDX_W-1:0]];
      end
      default: begin
        if (pos_i == '0)        bit_o = carry_i;
        else if (pos_i <= wl_i) bit_o = word_i[i_std[IDX_W-1:0]];
      end
    endcase
  end

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic [1:0]          slot_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic                sd_o,
  output logic                underrun_o
);

  localparam int unsigned POS_W = $clog2(SAMPLE_W) + 1;
  localparam int unsigned IDX_W = POS_W - 1;

  logic                fall, new_slot, frame_start;
  logic [POS_W-1:0]    pos_nx;
  logic [SAMPLE_W-1:0] left_nx, right_nx;

  fmt_e                fmt_q, fmt_nx;
  logic [POS_W-1:0]    wl_q, sl_q, wl_nx, sl_nx, wl_in, sl_in, i_msb;
  logic [SAMPLE_W-1:0] cur_word_q, word_nx;
  logic                carry, bit_nx, msb_nx, sd_q;

  aud_tx_slot_timer #(.POS_W(POS_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bclk_i       (bclk_i),
    .ws_i         (ws_i),
    .fall_o       (fall),
    .new_slot_o   (new_slot),
    .frame_start_o(frame_start),
    .pos_nx_o     (pos_nx)
  );

  aud_tx_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .left_i    (left_i),
    .right_i   (right_i),
    .ready_o   (ready_o),
    .load_i    (frame_start),
    .left_nx_o (left_nx),
    .right_nx_o(right_nx),
    .underrun_o(underrun_o)
  );

  always_comb begin
    sl_in = POS_W'(len_decode(slot_i));
    wl_in = POS_W'(len_decode(wlen_i));
    if (wl_in > sl_in) wl_in = sl_in;  // R12 clamp
    fmt_nx  = frame_start ? fmt_e'(fmt_i) : fmt_q;
    wl_nx   = frame_start ? wl_in : wl_q;
    sl_nx   = frame_start ? sl_in : sl_q;
    // R7: ws low -> left
    word_nx = new_slot ? (ws_i ? right_nx : left_nx) : cur_word_q;
    // R6: last bit of the previous slot under its own settings
    carry   = (wl_q == sl_q) ? cur_word_q[0] : 1'b0;
    i_msb   = wl_nx - POS_W'(1);
    msb_nx  = word_nx[i_msb[IDX_W-1:0]];
  end

  aud_tx_bit_sel #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_sel (
    .fmt_i  (fmt_nx),
    .wl_i   (wl_nx),
    .sl_i   (sl_nx),
    .pos_i  (pos_nx),
    .word_i (word_nx),
    .carry_i(carry),
    .bit_o  (bit_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q      <= FMT_STD;
      wl_q       <= POS_W'(16);
      sl_q       <= POS_W'(16);
      cur_word_q <= '0;
      sd_q       <= 1'b0;
    end else if (fall) begin
      fmt_q      <= fmt_nx;
      wl_q       <= wl_nx;
      sl_q       <= sl_nx;
      cur_word_q <= word_nx;
      sd_q       <= bit_nx;
    end
  end

  assign sd_o = sd_q;

  p_sd_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $past(fall));

  p_underrun_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);

  p_lj_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_slot && fmt_nx == FMT_LJ) |=> (sd_o == $past(msb_nx)));

  p_rj_lsb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !new_slot && fmt_q == FMT_RJ && pos_nx == sl_q - POS_W'(1))
      |=> (sd_o == $past(cur_word_q[0])));

  p_std_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_slot && (fmt_nx == FMT_STD || fmt_nx == FMT_STD3)) |=> (sd_o == $past(carry)));

endmodule

// File: tb/tb_aud_serial_tx.sv
`timescale 1ns/1ps
module tb_aud_serial_tx;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_i = 1'b1;
  logic        ws_i = 1'b1;
  logic [1:0]  fmt_i = 2'd0, wlen_i = 2'd0, slot_i = 2'd0;
  logic        valid_i = 1'b0;
  logic [31:0] left_i = '0, right_i = '0;
  logic        ready_o, sd_o, underrun_o;

  int checks = 0;
  int failures = 0;
  int ucnt = 0;
  int stable_err = 0;
  bit done = 0;

  logic [31:0] cap_l, cap_r, cur_l = '0, cur_r = '0;
  logic        prev_last = 1'b0;

  always #2.5 clk = ~clk;

  aud_serial_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk_i), .ws_i(ws_i),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .slot_i(slot_i),
    .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .ready_o(ready_o), .sd_o(sd_o), .underrun_o(underrun_o)
  );

  always @(negedge clk) if (underrun_o) ucnt++;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic [1:0]  sl;
    logic        push;
    logic [31:0] l;
    logic [31:0] r;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd0, 1'b1, 32'h0000_A5C3, 32'h0000_3C5A},
    '{2'd0, 2'd1, 2'd2, 1'b1, 32'h0080_0001, 32'h007F_FFFE},
    '{2'd0, 2'd2, 2'd2, 1'b1, 32'h8000_0001, 32'h1234_5679},
    '{2'd0, 2'd2, 2'd2, 1'b1, 32'h0F0F_0F0E, 32'hC000_0003},
    '{2'd1, 2'd0, 2'd1, 1'b1, 32'hFFFF_8001, 32'h0000_7FFF},
    '{2'd1, 2'd1, 2'd2, 1'b1, 32'hAB80_00FF, 32'h0012_3456},
    '{2'd2, 2'd0, 2'd1, 1'b1, 32'h0000_8001, 32'h0000_7FFE},
    '{2'd2, 2'd1, 2'd2, 1'b1, 32'h00F0_0000, 32'h000F_FFFF},
    '{2'd2, 2'd0, 2'd0, 1'b1, 32'h0000_C001, 32'h0000_2AAA},
    '{2'd2, 2'd0, 2'd1, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{2'd1, 2'd2, 2'd0, 1'b1, 32'h1234_8765, 32'h0000_0F0F},
    '{2'd3, 2'd1, 2'd1, 1'b1, 32'h0080_0003, 32'h0055_AA55}
  };

  function automatic int dec_len(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] lj_val(input int w, input int s, input logic [31:0] word);
    return (word & wmask(w)) << (s - w);
  endfunction

  // Expected slot contents as an s-bit value, sent MSB first
  function automatic logic [31:0] slot_val(input logic [1:0] f, input int w, input int s,
                                           input logic [31:0] word, input logic pl);
    logic [31:0] m, v;
    m = wmask(w);
    case (f)
      2'd1:    v = lj_val(w, s, word);                                  // R4
      2'd2:    v = (word & m) | (word[w-1] ? ~m : 32'd0);               // R5 sign fill
      default: v = (lj_val(w, s, word) >> 1) | ({31'd0, pl} << (s - 1)); // R3, R6
    endcase
    return v & wmask(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    valid_i = 1'b1; left_i = l; right_i = r;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_frame(input int s, input bit poke);
    logic a;
    cap_l = '0; cap_r = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < s; k++) begin
        @(negedge clk);
        bclk_i = 1'b0; ws_i = ch[0];
        @(negedge clk);
        a = sd_o;
        @(negedge clk);
        if (poke && ch == 0 && k == 2) begin
          fmt_i = 2'd2; wlen_i = 2'd1; slot_i = 2'd2;
        end
        bclk_i = 1'b1;
        repeat (2) @(negedge clk);
        if (a !== sd_o) stable_err++;
        if (ch == 0) cap_l[s-1-k] = sd_o;
        else         cap_r[s-1-k] = sd_o;
      end
    end
  endtask

  task automatic frame_and_check(input logic [1:0] f, input logic [1:0] wc, input logic [1:0] sc,
                                 input bit poke);
    int w, s;
    logic [31:0] el, er;
    string tag;
    s = dec_len(sc);
    w = dec_len(wc);
    if (w > s) w = s; // R12
    tag = (f == 2'd1) ? "R4" : (f == 2'd2) ? "R5" : "R3";
    el = slot_val(f, w, s, cur_l, prev_last);
    er = slot_val(f, w, s, cur_r, lj_val(w, s, cur_l) & 32'd1);
    fmt_i = f; wlen_i = wc; slot_i = sc;
    run_frame(s, poke);
    // R7: ws low slot carries left, ws high slot carries right; R2 MSB first
    check(poke ? "R11 left" : {tag, " R7 left"},  cap_l, el);
    check(poke ? "R11 right" : {tag, " R7 right"}, cap_r, er);
    prev_last = lj_val(w, s, cur_r) & 32'd1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sd", {31'd0, sd_o}, 32'd0);
    check("R1 ready", {31'd0, ready_o}, 32'd1);
    check("R1 underrun", {31'd0, underrun_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].push) begin
        push(VECS[i].l, VECS[i].r);
        cur_l = VECS[i].l; cur_r = VECS[i].r;  // R2: upper bits masked in model
        if (i == 0) check("R9 ready low when full", {31'd0, ready_o}, 32'd0);
      end
      frame_and_check(VECS[i].fmt, VECS[i].wl, VECS[i].sl, 1'b0);
      if (i == 0) check("R9 ready after frame start", {31'd0, ready_o}, 32'd1);
      // R10: only the frame without a pushed pair underruns, repeating the old pair
      if (i == 8) check("R10 no underrun", ucnt, 0);
      if (i == 9) check("R10 underrun count", ucnt, 1);
    end

    // R11: config poked mid-frame must not alter this frame
    push(32'h0000_9ABC, 32'h0000_1357);
    cur_l = 32'h0000_9ABC; cur_r = 32'h0000_1357;
    frame_and_check(2'd1, 2'd0, 2'd0, 1'b1);

    // R8: output stable across each bit period
    check("R8 stability", stable_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule